// File: doc/BRIEF.md
# Backplane Slot Address Decoder

This block is the card-side front end of a byte-wide multiplexed backplane bus. The bus address is 64 bits wide. The host sends it as eight one-byte address cycles, most significant byte first. Each address cycle also carries a three-bit index that names which byte of the address it holds. The card compares the top byte (index 7) against its strapped slot number, so the card knows whether it is addressed after that first address cycle. The next byte (index 6) is split as follows:

- bits 7:6 select one of four function sections;
- bits 5:4 select one of four segments within that function.

The segment codes are 0 for ROM, 1 for I/O, 2 for manufacturer identity and 3 for device identity. The card keeps only the low offset bytes it actually decodes (two bytes by default).

All address latches hold their values between accesses. A host can therefore step through sequential locations by sending only the low offset byte again, without repeating the slot select. Data cycles are marked by a data strobe and a read/write line. Each nibble of the data lines carries an even-parity bit. On reads, the card produces these parity bits itself. On writes, it checks them: a write with a mismatch is dropped and a sticky error flag is raised.

Reads of the ROM and I/O segments go to the card's local logic through a single-cycle read strobe. Without a ROM, the two identity segments answer with fixed values set by parameters. The local side has no back-pressure: a read strobe must be answered with data in the same cycle, and a write strobe is taken in the cycle it is raised.

Top module: `cbus_slot_decoder`

## Requirements
- R1: An address cycle with index 7 sets `card_sel` on the next clock to 1 if the byte equals `slot_id`, and to 0 otherwise. `card_sel` holds that value until the next index-7 address cycle.
- R2: An index-6 address cycle while selected loads the function from byte bits 7:6 and the segment from bits 5:4 (0 ROM, 1 I/O, 2 manufacturer ID, 3 device ID). Both appear on `loc_func` and `loc_seg` on the next clock.
- R3: While selected, index-0 and index-1 address cycles load bits 7:0 and 15:8 of `loc_off`. Index 2 to 5 cycles, and any address cycle while not selected (other than index 7), leave every latch unchanged.
- R4: Without an address cycle, `card_sel`, `loc_func`, `loc_seg` and `loc_off` keep their values. Resending only the low byte changes only `loc_off[7:0]`.
- R5: A read data cycle while selected raises `bus_ad_oe` in the same cycle. It also drives `bus_par_out[i]` as the XOR of bits 4i+3..4i of `bus_ad_out`. When not driving, both outputs are 0.
- R6: A read of the ROM or I/O segment raises `loc_rd` in the same cycle and puts `loc_rdata` on `bus_ad_out`.
- R7: A write data cycle while selected, with matching parity, to the I/O segment raises `loc_wr` in the same cycle, with `loc_wdata` equal to the bus byte.
- R8: A write data cycle while selected whose `bus_par_in` differs from the even parity of the byte does not raise `loc_wr`. It sets `par_err` on the next clock, and `par_err` stays set until reset.
- R9: A read of the manufacturer or device identity segment does not raise `loc_rd`. It returns the identity's low byte at offset 0, its high byte at offset 1, and 0x00 at any other offset.
- R10: Writes to the ROM, manufacturer ID and device ID segments are dropped (no `loc_wr`).
- R11: While `card_sel` is 0, `bus_ad_oe`, `loc_rd` and `loc_wr` stay 0.
- R12: When `bus_as` and `bus_ds` are high together, the cycle is an address cycle only. No data is driven and no local strobe is raised.
- R13: After reset, `card_sel`, `loc_func`, `loc_seg`, `loc_off` and `par_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_id | input | 8 | Strapped slot number of this card |
| bus_as | input | 1 | Address cycle strobe |
| bus_ds | input | 1 | Data cycle strobe |
| bus_rw | input | 1 | 1 = read, 0 = write, during a data cycle |
| bus_idx | input | 3 | Address byte index, 7 = most significant |
| bus_ad_in | input | 8 | Multiplexed address/data byte from the bus |
| bus_par_in | input | 2 | Even-parity bits for the two incoming nibbles |
| bus_ad_out | output | 8 | Read data driven by the card |
| bus_par_out | output | 2 | Even-parity bits for the read data nibbles |
| bus_ad_oe | output | 1 | Card is driving the data lines |
| card_sel | output | 1 | This card is addressed |
| loc_rd | output | 1 | Local read strobe (ROM or I/O) |
| loc_wr | output | 1 | Local write strobe (I/O) |
| loc_func | output | 2 | Latched function section |
| loc_seg | output | 2 | Latched segment code |
| loc_off | output | OFF_W | Latched segment offset |
| loc_wdata | output | 8 | Local write data |
| loc_rdata | input | 8 | Local read data, valid in the cycle `loc_rd` is high |
| par_err | output | 1 | Sticky write-parity error |

## Verification
The properties assume the following about the inputs:
- `bus_idx` is meaningful only while `bus_as` is high.
- `slot_id` is a static strap.
- `loc_rdata` answers combinationally in the strobe cycle, with no wait state.

The stimulus drives every input at the falling edge and holds `slot_id` fixed for the whole run. About half of the random index-7 bytes are made equal to the slot number, so that selected and unselected stretches both occur. Parity is corrupted on roughly a quarter of writes, and cycles with both strobes raised are mixed in deliberately to exercise the address-strobe priority.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  localparam int BUS_W    = 8;
  localparam int NIB_N    = BUS_W / 4;
  localparam int IDX_W    = 3;
  localparam int SLOT_IDX = 7;
  localparam int FSEL_IDX = 6;

  typedef enum logic [1:0] {
    SEG_ROM = 2'd0,
    SEG_IO  = 2'd1,
    SEG_MFR = 2'd2,
    SEG_DEV = 2'd3
  } seg_e;

  function automatic logic [NIB_N-1:0] nib_par(input logic [BUS_W-1:0] d);
    logic [NIB_N-1:0] p;
    for (int i = 0; i < NIB_N; i++) p[i] = ^d[4*i +: 4];
    return p;
  endfunction
endpackage

// File: rtl/cbus_parity.sv
module cbus_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0]   data,
  output logic [W/4-1:0] par
);
  localparam int NN = W / 4;
  for (genvar g = 0; g < NN; g++) begin : g_nib
    assign par[g] = ^data[4*g +: 4];
  end
endmodule

// File: rtl/cbus_addr_latch.sv
module cbus_addr_latch
  import cbus_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] slot_id,
  input  logic             as_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [BUS_W-1:0] ad_i,
  output logic             sel_o,
  output logic [1:0]       func_o,
  output seg_e             seg_o,
  output logic [OFF_W-1:0] off_o
);
  localparam int OFF_BYTES = (OFF_W + BUS_W - 1) / BUS_W;
  localparam int PAD_W     = OFF_BYTES * BUS_W;

  logic             sel_q;
  logic [1:0]       func_q;
  seg_e             seg_q;
  logic [PAD_W-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      func_q <= '0;
      seg_q  <= SEG_ROM;
      off_q  <= '0;
    end else if (as_i) begin
      if (idx_i == IDX_W'(SLOT_IDX)) begin
        sel_q <= (ad_i == slot_id);
      end else if (sel_q) begin
        if (idx_i == IDX_W'(FSEL_IDX)) begin
          func_q <= ad_i[7:6];
          seg_q  <= seg_e'(ad_i[5:4]);
        end
        for (int k = 0; k < OFF_BYTES; k++) begin
          if (idx_i == IDX_W'(k)) off_q[BUS_W*k +: BUS_W] <= ad_i;
        end
      end
    end
  end

  assign sel_o  = sel_q;
  assign func_o = func_q;
  assign seg_o  = seg_q;
  assign off_o  = off_q[OFF_W-1:0];
endmodule

// File: rtl/cbus_resp.sv
module cbus_resp
  import cbus_pkg::*;
#(
  parameter int          OFF_W   = 16,
  parameter bit          HAS_ROM = 1'b0,
  parameter logic [15:0] MFR_ID  = 16'h1D0C,
  parameter logic [15:0] DEV_ID  = 16'h0042
) (
  input  seg_e             seg_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [BUS_W-1:0] loc_rdata_i,
  output logic             use_local_o,
  output logic [BUS_W-1:0] rd_data_o
);
  if (HAS_ROM) begin : g_rom
    assign use_local_o = 1'b1;
    assign rd_data_o   = loc_rdata_i;
  end else begin : g_fixed
    logic [15:0]      id_word;
    logic [BUS_W-1:0] id_byte;
    always_comb begin
      id_word = (seg_i == SEG_MFR) ? MFR_ID : DEV_ID;
      if (off_i > OFF_W'(1)) id_byte = '0;
      else if (off_i[0])     id_byte = id_word[15:8];
      else                   id_byte = id_word[7:0];
    end
    assign use_local_o = (seg_i == SEG_ROM) || (seg_i == SEG_IO);
    assign rd_data_o   = use_local_o ? loc_rdata_i : id_byte;
  end
endmodule

// File: rtl/cbus_slot_decoder.sv
module cbus_slot_decoder
  import cbus_pkg::*;
#(
  parameter int          OFF_W   = 16,
  parameter bit          HAS_ROM = 1'b0,
  parameter logic [15:0] MFR_ID  = 16'h1D0C,
  parameter logic [15:0] DEV_ID  = 16'h0042
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       slot_id,
  input  logic             bus_as,
  input  logic             bus_ds,
  input  logic             bus_rw,
  input  logic [2:0]       bus_idx,
  input  logic [7:0]       bus_ad_in,
  input  logic [1:0]       bus_par_in,
  output logic [7:0]       bus_ad_out,
  output logic [1:0]       bus_par_out,
  output logic             bus_ad_oe,
  output logic             card_sel,
  output logic             loc_rd,
  output logic             loc_wr,
  output logic [1:0]       loc_func,
  output logic [1:0]       loc_seg,
  output logic [OFF_W-1:0] loc_off,
  output logic [7:0]       loc_wdata,
  input  logic [7:0]       loc_rdata,
  output logic             par_err
);
  seg_e             seg;
  logic             use_local;
  logic [BUS_W-1:0] rd_data;
  logic [NIB_N-1:0] par_chk, par_gen;
  logic             rd_cyc, wr_cyc, par_ok, err_q;

  cbus_addr_latch #(.OFF_W(OFF_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .slot_id(slot_id),
    .as_i(bus_as), .idx_i(bus_idx), .ad_i(bus_ad_in),
    .sel_o(card_sel), .func_o(loc_func), .seg_o(seg), .off_o(loc_off)
  );

  cbus_resp #(.OFF_W(OFF_W), .HAS_ROM(HAS_ROM), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_resp (
    .seg_i(seg), .off_i(loc_off), .loc_rdata_i(loc_rdata),
    .use_local_o(use_local), .rd_data_o(rd_data)
  );

  cbus_parity #(.W(BUS_W)) u_par_chk (.data(bus_ad_in), .par(par_chk));
  cbus_parity #(.W(BUS_W)) u_par_gen (.data(rd_data),   .par(par_gen));

  assign rd_cyc = bus_ds && !bus_as && bus_rw  && card_sel;
  assign wr_cyc = bus_ds && !bus_as && !bus_rw && card_sel;
  assign par_ok = (par_chk == bus_par_in);

  assign loc_seg     = seg;
  assign loc_rd      = rd_cyc && use_local;
  assign loc_wr      = wr_cyc && par_ok && (seg == SEG_IO);
  assign loc_wdata   = bus_ad_in;
  assign bus_ad_oe   = rd_cyc;
  assign bus_ad_out  = rd_cyc ? rd_data : '0;
  assign bus_par_out = rd_cyc ? par_gen : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 err_q <= 1'b0;
    else if (wr_cyc && !par_ok) err_q <= 1'b1;
  end
  assign par_err = err_q;
endmodule

// File: rtl/cbus_slot_decoder_chk.sv
module cbus_slot_decoder_chk
  import cbus_pkg::*;
#(
  parameter int          OFF_W   = 16,
  parameter bit          HAS_ROM = 1'b0,
  parameter logic [15:0] MFR_ID  = 16'h1D0C
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       slot_id,
  input logic             bus_as,
  input logic             bus_ds,
  input logic [2:0]       bus_idx,
  input logic [7:0]       bus_ad_in,
  input logic [1:0]       bus_par_in,
  input logic [7:0]       bus_ad_out,
  input logic [1:0]       bus_par_out,
  input logic             bus_ad_oe,
  input logic             card_sel,
  input logic             loc_rd,
  input logic             loc_wr,
  input logic [1:0]       loc_func,
  input logic [1:0]       loc_seg,
  input logic [OFF_W-1:0] loc_off,
  input logic [7:0]       loc_rdata,
  input logic             par_err
);
  assert_slot_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && bus_idx == 3'd7) |=> (card_sel == ($past(bus_ad_in) == $past(slot_id))));

  assert_fsel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && bus_idx == 3'd6 && card_sel) |=>
      (loc_func == $past(bus_ad_in[7:6]) && loc_seg == $past(bus_ad_in[5:4])));

  assert_off_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && bus_idx == 3'd0 && card_sel) |=> (loc_off[7:0] == $past(bus_ad_in)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_as |=> ($stable(card_sel) && $stable(loc_func) && $stable(loc_seg) && $stable(loc_off)));

  assert_read_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ad_oe |-> (bus_par_out == nib_par(bus_ad_out)));

  assert_local_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    loc_rd |-> (bus_ad_oe && bus_ad_out == loc_rdata && loc_seg inside {2'd0, 2'd1}));

  assert_write_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wr |-> (nib_par(bus_ad_in) == bus_par_in));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> par_err);

  assert_mfr_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_ROM && bus_ad_oe && loc_seg == 2'd2 && loc_off == '0) |-> (bus_ad_out == MFR_ID[7:0] && !loc_rd));

  assert_write_seg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wr |-> (loc_seg == 2'd1));

  assert_unselected_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !card_sel |-> (!bus_ad_oe && !loc_rd && !loc_wr));

  assert_as_priority_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && bus_ds) |-> (!bus_ad_oe && !loc_rd && !loc_wr));
endmodule

bind cbus_slot_decoder cbus_slot_decoder_chk #(
  .OFF_W(OFF_W), .HAS_ROM(HAS_ROM), .MFR_ID(MFR_ID)
) u_chk (.*);

// File: tb/cbus_slot_decoder_bench.sv
`timescale 1ns/1ps
module cbus_slot_decoder_bench;
  localparam logic [7:0]  SLOT = 8'h3C;
  localparam logic [15:0] MFR  = 16'h1D0C;
  localparam logic [15:0] DEV  = 16'h0042;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_as = 0, bus_ds = 0, bus_rw = 0;
  logic [2:0] bus_idx = '0;
  logic [7:0] bus_ad_in = '0;
  logic [1:0] bus_par_in = '0;
  logic [7:0] bus_ad_out, loc_wdata, loc_rdata;
  logic [1:0] bus_par_out, loc_func, loc_seg;
  logic [15:0] loc_off;
  logic bus_ad_oe, card_sel, loc_rd, loc_wr, par_err;

  int n_tests = 0;
  int n_fail  = 0;

  // model state
  logic       m_sel = 0, m_err = 0;
  logic [1:0] m_func = 0, m_seg = 0;
  logic [15:0] m_off = 0;

  always #2.5 clk = ~clk;

  assign loc_rdata = {loc_func, loc_seg, loc_off[3:0]} ^ 8'h5A;

  cbus_slot_decoder u_cbus_slot_decoder (
    .clk(clk), .rst_n(rst_n), .slot_id(SLOT),
    .bus_as(bus_as), .bus_ds(bus_ds), .bus_rw(bus_rw), .bus_idx(bus_idx),
    .bus_ad_in(bus_ad_in), .bus_par_in(bus_par_in),
    .bus_ad_out(bus_ad_out), .bus_par_out(bus_par_out), .bus_ad_oe(bus_ad_oe),
    .card_sel(card_sel), .loc_rd(loc_rd), .loc_wr(loc_wr),
    .loc_func(loc_func), .loc_seg(loc_seg), .loc_off(loc_off),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .par_err(par_err)
  );

  function automatic logic [1:0] epar(input logic [7:0] d);
    return {^d[7:4], ^d[3:0]};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] f, input logic [1:0] s, input logic [15:0] o);
    logic [15:0] id;
    if (s == 2'd0 || s == 2'd1) return {f, s, o[3:0]} ^ 8'h5A;
    id = (s == 2'd2) ? MFR : DEV;
    if (o > 16'd1) return 8'h00;
    return o[0] ? id[15:8] : id[7:0];
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input bit as, input bit ds, input bit rw,
                       input logic [2:0] idx, input logic [7:0] d, input logic [1:0] p);
    bit rd, wr, pok, ewr;
    @(negedge clk);
    bus_as = as; bus_ds = ds; bus_rw = rw; bus_idx = idx; bus_ad_in = d; bus_par_in = p;
    #1;
    rd  = ds && rw && !as && m_sel;
    wr  = ds && !rw && !as && m_sel;
    pok = (p == epar(d));
    check(!m_sel ? "R11 oe" : (as ? "R12 oe" : "R5 oe"), bus_ad_oe, rd);
    if (rd) begin
      check((m_seg < 2) ? "R6 data" : "R9 data", bus_ad_out, exp_rd(m_func, m_seg, m_off));
      check("R5 parity", bus_par_out, epar(exp_rd(m_func, m_seg, m_off)));
      check((m_seg < 2) ? "R6 loc_rd" : "R9 loc_rd", loc_rd, m_seg < 2);
    end else begin
      check("R11 loc_rd idle", loc_rd, 0);
      check("R5 idle bus", {bus_par_out, bus_ad_out}, 0);
    end
    ewr = wr && pok && (m_seg == 2'd1);
    check(!pok && wr ? "R8 loc_wr" : ((wr && m_seg != 2'd1) ? "R10 loc_wr" : "R7 loc_wr"), loc_wr, ewr);
    if (ewr) check("R7 wdata", loc_wdata, d);
    @(posedge clk);
    if (as) begin
      if (idx == 3'd7) m_sel = (d == SLOT);
      else if (m_sel) begin
        if (idx == 3'd6) begin m_func = d[7:6]; m_seg = d[5:4]; end
        if (idx == 3'd0) m_off[7:0]  = d;
        if (idx == 3'd1) m_off[15:8] = d;
      end
    end
    if (wr && !pok) m_err = 1'b1;
    #1;
    check("R1 card_sel", card_sel, m_sel);
    check("R2 func/seg", {loc_func, loc_seg}, {m_func, m_seg});
    check((as && idx < 3'd2) ? "R3 offset" : "R4 offset hold", loc_off, m_off);
    check("R8 par_err", par_err, m_err);
  endtask

  task automatic addr(input logic [2:0] idx, input logic [7:0] d);
    do_op(1'b1, 1'b0, 1'b0, idx, d, epar(d));
  endtask
  task automatic rd_op();
    do_op(1'b0, 1'b1, 1'b1, 3'd0, 8'h00, 2'b00);
  endtask
  task automatic wr_op(input logic [7:0] d, input bit bad);
    do_op(1'b0, 1'b1, 1'b0, 3'd0, d, epar(d) ^ {1'b0, bad});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5EED);
    repeat (3) @(posedge clk);
    #1;
    // R13 reset state
    check("R13 reset sel", card_sel, 0);
    check("R13 reset latches", {loc_func, loc_seg, loc_off}, 0);
    check("R13 reset err", par_err, 0);
    @(negedge clk); rst_n = 1'b1;

    // R11 unselected: reads and writes do nothing
    rd_op(); wr_op(8'h11, 0);
    addr(3'd6, 8'h90);            // ignored while unselected (R3)
    addr(3'd7, SLOT);             // R1 select
    addr(3'd6, {2'd2, 2'd1, 4'h0}); // func 2, I/O
    addr(3'd1, 8'h00); addr(3'd0, 8'h07);
    rd_op();                      // R6 local read
    wr_op(8'hC3, 0);              // R7 write
    addr(3'd0, 8'h08); rd_op();   // R4 low byte only
    addr(3'd3, 8'hFF); addr(3'd5, 8'hEE); // R3 no effect
    addr(3'd6, {2'd1, 2'd0, 4'h0}); wr_op(8'h21, 0); // R10 ROM write dropped
    addr(3'd6, {2'd0, 2'd2, 4'h0});
    addr(3'd0, 8'h00); rd_op();   // R9 mfr low
    addr(3'd0, 8'h01); rd_op();   // R9 mfr high
    addr(3'd0, 8'h02); rd_op();   // R9 beyond id
    wr_op(8'h33, 0);              // R10 id write dropped
    addr(3'd6, {2'd3, 2'd3, 4'h0}); addr(3'd0, 8'h01); rd_op(); // R9 dev
    addr(3'd6, {2'd0, 2'd1, 4'h0});
    wr_op(8'h5A, 1);              // R8 bad parity
    wr_op(8'h5A, 0);              // R8 sticky stays, good write goes
    do_op(1'b1, 1'b1, 1'b1, 3'd0, 8'h44, epar(8'h44)); // R12
    addr(3'd7, SLOT ^ 8'h01); rd_op(); // R11 deselected

    for (int i = 0; i < 600; i++) begin
      int r;
      logic [2:0] ix;
      logic [7:0] dv;
      r  = $urandom % 8;
      ix = 3'($urandom % 8);
      dv = 8'($urandom);
      case (r)
        0, 1, 2: begin
          if (ix == 3'd7 && ($urandom % 2)) dv = SLOT;
          addr(ix, dv);
        end
        3, 4: rd_op();
        5, 6: wr_op(dv, ($urandom % 4) == 0);
        default: do_op(1'b1, 1'b1, 1'($urandom % 2), ix, dv, epar(dv));
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule